// File: doc/BRIEF.md
# Stop-Mode Wakeup Controller

This block decides when a small processor core may halt its clock for low power and when it gets the clock back. The core raises a stop request. The controller then gates the core clock off and watches a set of wakeup pins on an always-on slow clock. There is one dedicated active-high wake pin and four active-low key pins. Each key pin has its own enable bit. A release-mode input chooses between two behaviours. In level release, any active level on the wake pin or on an enabled key pin ends the stop. In edge release, only a rising edge on the wake pin ends it, and the key pins have no effect.

A release does not restart the clock at once. The controller first runs a warm-up count, which a configuration write can set and which is 16 after reset. When the count ends, the controller gives the core one `resume` pulse and returns to normal running.

In level release, a wake condition may already be present when the stop request arrives. In that case the controller never enters the stopped state and goes straight to warm-up. A status bit records whether the last wakeup came from a key pin or from the wake pin.

Top module: `stopwake_ctrl`

## Requirements
- R1: With `level_mode`=1, a high level on `wake_pin` during stop releases it (`stopped` falls and warm-up begins).
- R2: With `level_mode`=1, a low level on key pin i releases stop only when `key_en[i]`=1. A low key pin whose enable bit is 0 leaves `stopped` high.
- R3: With `level_mode`=0, only a 0-to-1 change of `wake_pin` releases stop. Key pins have no effect whatever `key_en` holds. A wake pin that is already high when stop begins does not release until it goes low and then high again.
- R4: With `level_mode`=1, if `wake_pin` is high or any enabled key pin is low when `stop_req` is accepted, `stopped` never rises and warm-up starts at the same clock edge.
- R5: Warm-up keeps `core_clk_en` and `stopped` low for max(N,1) cycles. N is the last value written through `cfg_wr`/`cfg_warm`, and it is 16 after reset. While the stop is in force, `core_clk_en` is also low.
- R6: After warm-up, `resume` is high for exactly one cycle with `core_clk_en` high. The block then runs with `resume` low.
- R7: `stop_req` is acted on only while running. A request during stop or warm-up is ignored, and `stopped` cannot rise straight out of warm-up.
- R8: `wake_src_key` is 1 when the last release came only from a key pin and 0 when `wake_pin` took part, because the wake pin wins. An accepted stop request clears it, unless that same request aborts on a key pin.
- R9: Every wakeup pin passes through a two-flop synchronizer. A pin change made between edges ends the stop at the third following clock edge, and an accepted `stop_req` takes effect at the next edge.
- R10: After reset, `core_clk_en`=1 and `stopped`, `resume` and `wake_src_key` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on slow clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| stop_req | input | 1 | Core asks to enter stop |
| wake_pin | input | 1 | Dedicated wake pin, active high, asynchronous |
| key_pin | input | NKEY | Key wake pins, active low, asynchronous |
| key_en | input | NKEY | Per-key enable bits from the control register |
| level_mode | input | 1 | 1 = level release, 0 = wake-pin rising-edge release |
| cfg_wr | input | 1 | Write strobe for the warm-up count |
| cfg_warm | input | WARM_W | Warm-up count value to write |
| core_clk_en | output | 1 | Core clock enable |
| stopped | output | 1 | High while in stop |
| resume | output | 1 | One-cycle pulse when the core clock returns |
| wake_src_key | output | 1 | Source of the last wakeup: 1 key pin, 0 wake pin |

## Verification
An accepted stop request shows on `stopped` one edge later. A pin change made at a falling edge ends the stop on the third rising edge after it, so the bench checks `stopped` is still high after two edges and low after the third. From there the bench counts falling-edge samples with the clock off and the block not stopped, and compares the count against max(N,1). It expects `resume` on the very next sample and expects it gone one sample later. Every sample is taken at the falling edge, half a period away from the edge that moves the state.

// File: rtl/stopwake_pkg.sv
package stopwake_pkg;

  typedef enum logic [1:0] {
    SW_RUN  = 2'd0,
    SW_STOP = 2'd1,
    SW_WARM = 2'd2,
    SW_DONE = 2'd3
  } sw_state_e;

endpackage

// File: rtl/swk_sync.sv
// Two-flop synchronizer for asynchronous wake pins.
module swk_sync #(
  parameter int            W       = 1,
  parameter logic [W-1:0]  RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_async,
  output logic [W-1:0] q_sync
);

  logic [W-1:0] meta_q;
  logic [W-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= RST_VAL;
      sync_q <= RST_VAL;
    end else begin
      meta_q <= d_async;
      sync_q <= meta_q;
    end
  end

  assign q_sync = sync_q;

endmodule

// File: rtl/swk_release_detect.sv
// Computes the release condition from synchronized pins and the release mode.
module swk_release_detect #(
  parameter int NKEY = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wake_s,
  input  logic [NKEY-1:0] key_s,
  input  logic [NKEY-1:0] key_en,
  input  logic            level_mode,
  output logic            rel,
  output logic            rel_src_key
);

  logic            wake_prev_q;
  logic            wake_rise;
  logic            rel_wake;
  logic            rel_key;
  logic [NKEY-1:0] key_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wake_prev_q <= 1'b0;
    else        wake_prev_q <= wake_s;
  end

  assign wake_rise = wake_s & ~wake_prev_q;

  genvar gi;
  generate
    for (gi = 0; gi < NKEY; gi++) begin : g_key
      assign key_hit[gi] = key_en[gi] & ~key_s[gi];
    end
  endgenerate

  always_comb begin
    if (level_mode) begin
      rel_wake = wake_s;
      rel_key  = |key_hit;
    end else begin
      rel_wake = wake_rise;
      rel_key  = 1'b0;
    end
  end

  assign rel         = rel_wake | rel_key;
  assign rel_src_key = rel_key & ~rel_wake;

endmodule

// File: rtl/swk_warm_timer.sv
// Holds the warm-up count setting and runs the warm-up down-counter.
module swk_warm_timer #(
  parameter int          WARM_W       = 8,
  parameter int unsigned WARM_DEFAULT = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic [WARM_W-1:0] cfg_warm,
  input  logic              load,
  input  logic              run,
  output logic              warm_done
);

  localparam logic [WARM_W-1:0] RST_SETTING = WARM_W'(WARM_DEFAULT);
  localparam logic [WARM_W-1:0] ONE         = WARM_W'(1);

  logic [WARM_W-1:0] setting_q;
  logic [WARM_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      setting_q <= RST_SETTING;
    else if (cfg_wr) setting_q <= cfg_warm;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   cnt_q <= '0;
    else if (load)                cnt_q <= setting_q;
    else if (run && cnt_q > ONE)  cnt_q <= cnt_q - ONE;
  end

  assign warm_done = (cnt_q <= ONE);

endmodule

// File: rtl/stopwake_ctrl.sv
// Stop-mode entry/exit controller with warm-up before clock restart.
module stopwake_ctrl
  import stopwake_pkg::*;
#(
  parameter int          NKEY         = 4,
  parameter int          WARM_W       = 8,
  parameter int unsigned WARM_DEFAULT = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stop_req,
  input  logic              wake_pin,
  input  logic [NKEY-1:0]   key_pin,
  input  logic [NKEY-1:0]   key_en,
  input  logic              level_mode,
  input  logic              cfg_wr,
  input  logic [WARM_W-1:0] cfg_warm,
  output logic              core_clk_en,
  output logic              stopped,
  output logic              resume,
  output logic              wake_src_key
);

  localparam logic [NKEY-1:0] KEY_IDLE = {NKEY{1'b1}};

  sw_state_e       st_q, st_d;
  logic            wake_s;
  logic [NKEY-1:0] key_s;
  logic            rel, rel_src_key;
  logic            warm_load, warm_done;
  logic            src_set, src_clr, src_val;
  logic            src_q;

  swk_sync #(.W(1), .RST_VAL(1'b0)) u_sync_wake (
    .clk(clk), .rst_n(rst_n), .d_async(wake_pin), .q_sync(wake_s)
  );

  swk_sync #(.W(NKEY), .RST_VAL(KEY_IDLE)) u_sync_key (
    .clk(clk), .rst_n(rst_n), .d_async(key_pin), .q_sync(key_s)
  );

  swk_release_detect #(.NKEY(NKEY)) u_detect (
    .clk(clk), .rst_n(rst_n), .wake_s(wake_s), .key_s(key_s),
    .key_en(key_en), .level_mode(level_mode),
    .rel(rel), .rel_src_key(rel_src_key)
  );

  swk_warm_timer #(.WARM_W(WARM_W), .WARM_DEFAULT(WARM_DEFAULT)) u_timer (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_warm(cfg_warm),
    .load(warm_load), .run(st_q == SW_WARM), .warm_done(warm_done)
  );

  always_comb begin
    st_d      = st_q;
    warm_load = 1'b0;
    src_set   = 1'b0;
    src_clr   = 1'b0;
    src_val   = 1'b0;
    case (st_q)
      SW_RUN: begin
        if (stop_req) begin
          src_clr = 1'b1;
          if (level_mode && rel) begin
            // release level already present: skip stop, go to warm-up
            st_d      = SW_WARM;
            warm_load = 1'b1;
            src_set   = 1'b1;
            src_val   = rel_src_key;
          end else begin
            st_d = SW_STOP;
          end
        end
      end
      SW_STOP: begin
        if (rel) begin
          st_d      = SW_WARM;
          warm_load = 1'b1;
          src_set   = 1'b1;
          src_val   = rel_src_key;
        end
      end
      SW_WARM: begin
        if (warm_done) st_d = SW_DONE;
      end
      default: st_d = SW_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= SW_RUN;
    else        st_q <= st_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       src_q <= 1'b0;
    else if (src_set) src_q <= src_val;
    else if (src_clr) src_q <= 1'b0;
  end

  assign core_clk_en  = (st_q == SW_RUN) || (st_q == SW_DONE);
  assign stopped      = (st_q == SW_STOP);
  assign resume       = (st_q == SW_DONE);
  assign wake_src_key = src_q;

endmodule

// File: rtl/stopwake_ctrl_chk.sv
module stopwake_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic stop_req,
  input logic core_clk_en,
  input logic stopped,
  input logic resume
);

  AST_RESUME_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    resume |=> !resume); // R6

  AST_RESUME_AFTER_WARM: assert property (@(posedge clk) disable iff (!rst_n)
    resume |-> $past(!core_clk_en && !stopped)); // R5

  AST_STOPPED_CLK_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    stopped |-> !core_clk_en); // R5

  AST_STOP_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stopped) |-> $past(stop_req)); // R9

  AST_NO_STOP_FROM_WARM: assert property (@(posedge clk) disable iff (!rst_n)
    (!core_clk_en && !stopped) |=> !stopped); // R7

endmodule

bind stopwake_ctrl stopwake_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .stop_req(stop_req),
  .core_clk_en(core_clk_en), .stopped(stopped), .resume(resume)
);

// File: tb/stopwake_ctrl_bench.sv
module stopwake_ctrl_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       stop_req = 1'b0;
  logic       wake_pin = 1'b0;
  logic [3:0] key_pin = 4'hF;
  logic [3:0] key_en = 4'h0;
  logic       level_mode = 1'b1;
  logic       cfg_wr = 1'b0;
  logic [7:0] cfg_warm = 8'd0;
  logic       core_clk_en, stopped, resume, wake_src_key;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  stopwake_ctrl u_stopwake_ctrl (
    .clk(clk), .rst_n(rst_n), .stop_req(stop_req), .wake_pin(wake_pin),
    .key_pin(key_pin), .key_en(key_en), .level_mode(level_mode),
    .cfg_wr(cfg_wr), .cfg_warm(cfg_warm), .core_clk_en(core_clk_en),
    .stopped(stopped), .resume(resume), .wake_src_key(wake_src_key)
  );

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic bit exp_abort(bit lvl, logic [3:0] en, bit wk, logic [3:0] ky);
    return lvl && (wk || ((~ky & en) != 4'h0));
  endfunction

  // ev_kind: 0 wake high, 1 keys low, 2 both
  function automatic bit exp_release(bit lvl, logic [3:0] en, int ev_kind, logic [3:0] ev_key);
    return (ev_kind != 1) || (lvl && ((ev_key & en) != 4'h0));
  endfunction

  function automatic int exp_warm(int n);
    return (n < 1) ? 1 : n;
  endfunction

  task automatic set_warm(int n);
    cfg_warm = 8'(n);
    cfg_wr   = 1'b1;
    @(negedge clk);
    cfg_wr   = 1'b0;
  endtask

  // Called on the first warm-up sample; counts warm-up cycles and checks resume.
  task automatic finish_warm(int n, bit poke, bit exp_src);
    int c = 1;
    chk("R5 warmup clock off", int'(core_clk_en), 0);
    chk("R8 source bit", int'(wake_src_key), int'(exp_src));
    if (poke) stop_req = 1'b1;
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      stop_req = 1'b0;
      if (!core_clk_en && !stopped) c++;
      else break;
    end
    chk("R5 warmup length", c, exp_warm(n));
    chk("R6 resume pulse", int'(resume), 1);
    chk("R6 clock back", int'(core_clk_en), 1);
    @(negedge clk);
    chk("R6 resume single", int'(resume), 0);
    chk("R7 no stop after warmup", int'(stopped), 0);
    chk("R8 source held", int'(wake_src_key), int'(exp_src));
  endtask

  task automatic scenario(bit lvl, logic [3:0] en, bit pre_wk, logic [3:0] pre_key,
                          int ev_kind, logic [3:0] ev_key, int n, bit poke);
    bit ab, rl;
    level_mode = lvl;
    key_en     = en;
    wake_pin   = 1'b0;
    key_pin    = 4'hF;
    repeat (4) @(negedge clk);
    wake_pin = pre_wk;
    key_pin  = pre_key;
    repeat (4) @(negedge clk);
    ab = exp_abort(lvl, en, pre_wk, pre_key);
    stop_req = 1'b1;
    @(negedge clk);
    stop_req = 1'b0;
    chk("R9 stop entry next edge", int'(stopped), int'(!ab));
    chk("R4 clock off at request", int'(core_clk_en), 0);
    if (ab) begin
      finish_warm(n, poke, !pre_wk); // R4 abort path
      return;
    end
    chk("R8 source cleared by stop", int'(wake_src_key), 0);
    wake_pin = 1'b0;
    key_pin  = 4'hF;
    stop_req = poke;
    @(negedge clk);
    stop_req = 1'b0;
    repeat (3) @(negedge clk);
    chk("R3 R7 still stopped", int'(stopped), 1);
    rl = exp_release(lvl, en, ev_kind, ev_key);
    if (ev_kind != 1) wake_pin = 1'b1;
    if (ev_kind != 0) key_pin = ~ev_key;
    repeat (2) @(negedge clk);
    chk("R9 not yet released", int'(stopped), 1);
    @(negedge clk);
    chk("R1 R2 R3 release on third edge", int'(stopped), int'(!rl));
    if (!rl) begin
      repeat (6) @(negedge clk);
      chk("R2 R3 key ignored", int'(stopped), 1);
      wake_pin = 1'b1;
      repeat (3) @(negedge clk);
      chk("R1 R3 wake releases", int'(stopped), 0);
      finish_warm(n, poke, 1'b0);
    end else begin
      finish_warm(n, poke, ev_kind == 1);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'd4242);
    repeat (3) @(negedge clk);
    chk("R10 reset clk_en", int'(core_clk_en), 1);
    chk("R10 reset stopped", int'(stopped), 0);
    chk("R10 reset resume", int'(resume), 0);
    chk("R10 reset source", int'(wake_src_key), 0);
    rst_n = 1'b1;
    @(negedge clk);
    // directed corners
    scenario(1'b1, 4'h0, 1'b0, 4'hF, 0, 4'h0, 16, 1'b0); // R1, R5 default 16
    set_warm(5);
    scenario(1'b1, 4'h5, 1'b0, 4'hF, 1, 4'h4, 5, 1'b0);  // R2 enabled key
    scenario(1'b1, 4'h5, 1'b0, 4'hF, 1, 4'hA, 5, 1'b1);  // R2 disabled key, R7
    scenario(1'b0, 4'hF, 1'b0, 4'hF, 1, 4'hF, 5, 1'b0);  // R3 keys ignored
    scenario(1'b0, 4'hF, 1'b1, 4'h0, 0, 4'h0, 5, 1'b0);  // R3 high at entry
    scenario(1'b1, 4'h2, 1'b0, 4'hD, 0, 4'h0, 5, 1'b1);  // R4 abort by key
    scenario(1'b1, 4'h0, 1'b1, 4'hF, 0, 4'h0, 5, 1'b0);  // R4 abort by wake
    set_warm(0);
    scenario(1'b1, 4'h1, 1'b0, 4'hF, 2, 4'h1, 0, 1'b0);  // R8 wake wins, N=0
    set_warm(1);
    scenario(1'b0, 4'h0, 1'b0, 4'hF, 0, 4'h0, 1, 1'b1);  // N=1
    // constrained random
    for (int k = 0; k < 40; k++) begin
      int n = int'($urandom_range(0, 20));
      bit lvl = 1'($urandom_range(0, 1));
      logic [3:0] en = 4'($urandom_range(0, 15));
      bit pw = ($urandom_range(0, 3) == 0);
      logic [3:0] pk = ($urandom_range(0, 2) == 0) ? 4'($urandom_range(0, 15)) : 4'hF;
      int kind = int'($urandom_range(0, 2));
      logic [3:0] ek = 4'($urandom_range(1, 15));
      bit pk_poke = 1'($urandom_range(0, 1));
      set_warm(n);
      scenario(lvl, en, pw, pk, kind, ek, n, pk_poke);
    end
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule